// File: doc/BRIEF.md
# Internal Clock Postscaler and Frequency Switch

This block builds the internal system clock from two free-running sources: a fast base oscillator and a separate slow low-power oscillator. A 3-bit frequency-select input chooses the output: the six nonzero codes below the top one pick successive divide-by-two taps of the base, the top code passes the base through undivided, and code zero routes the slow oscillator to the output. The select may change at any moment, even while an earlier change is still being handled.

Every change is a staged handover. The clock now driving the output is gated off during its low phase, and only then is the new clock gated on, also during its low phase. The new setting counts as in effect after eight falling edges of the new clock. A status flag reports that the fast-derived clock is stable. Leaving the slow oscillator starts a warm-up timer counted in base-clock cycles, and the flag stays low until it expires. Moving between fast-derived codes leaves the flag high. Moving to the slow oscillator drops it at once.

Top module: `intosc_postscaler`

## Requirements
- R1: After reset the output follows the slow oscillator and `freq_stable` is low.
- R2: Select code 0 gives an output period equal to the slow oscillator period.
- R3: Select code 7 gives an output period equal to the base clock period.
- R4: Select code c in 1..6 gives an output period of the base period times 2^(7-c), so code 6 divides by 2 and code 1 by 64.
- R5: After a change from an in-effect code 0 to a nonzero code, `freq_stable` stays low for at least WARM_CYCLES base cycles after the change and is high within 40 base cycles after that.
- R6: While the warm-up timer runs, the output keeps toggling.
- R7: After a change, the new frequency appears at the output once eight falling edges of the new clock have passed, plus at most two periods of the old clock and one of the new clock for alignment.
- R8: No high or low output pulse is shorter than half the period of the faster of the old and new clocks. The fast path and the slow path are never gated on together.
- R9: A change between two nonzero codes never lowers `freq_stable`.
- R10: A change from a nonzero code to code 0 lowers `freq_stable` within 6 base cycles, and the output then follows the slow oscillator.
- R11: A new code written while a handover is pending redirects it to the newest code. Whether the warm-up applies depends on the code last fully in effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast base oscillator |
| clk_slow | input | 1 | Slow low-power oscillator, asynchronous to clk_fast |
| rst_n | input | 1 | Asynchronous active-low reset |
| freq_sel | input | SEL_W (3) | Frequency select code, may change at any time |
| clk_out | output | 1 | Glitch-free system clock |
| freq_stable | output | 1 | High when the fast-derived clock is settled |

## Verification
The hazardous overlap is a new code arriving while an earlier handover is still in flight. In that case the release of one clock, the warm-up timer and the engagement of another clock all act in the same cycles. The bench provokes this by writing a second code a few cycles after the first. It does this both out of the slow source and out of a pending move to the slow source. It then judges the result by the final output period, by the flag level, and by the shortest pulse recorded across the whole overlap. It also sweeps every ordered pair of nonzero codes and computes each expected period and pulse bound arithmetically.

// File: rtl/osc_pkg.sv
package osc_pkg;
  // Handover phases of the frequency switch controller
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,  // selected code fully in effect
    PH_REL  = 2'd1,  // gating off whichever clock is on
    PH_ENG  = 2'd2,  // gating on the destination clock
    PH_SET  = 2'd3   // counting falling edges of the destination clock
  } osc_phase_e;
endpackage

// File: rtl/osc_rst_sync.sv
// Asynchronous assert, synchronous release reset bridge.
module osc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/osc_tap_divider.sv
// Binary ripple-free divider: bit k toggles every 2^k base cycles.
module osc_tap_divider #(
  parameter int DIV_W = 6
) (
  input  logic             clk_fast,
  input  logic             rst_n,
  output logic [DIV_W-1:0] div_cnt
);
  logic [DIV_W-1:0] cnt_q, cnt_n;

  always_comb cnt_n = cnt_q + 1'b1;

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign div_cnt = cnt_q;
endmodule

// File: rtl/osc_slow_gate.sv
// Slow-side gate: follows the request from the fast controller, changing
// only on falling edges of the slow clock so the gated clock never slivers.
module osc_slow_gate (
  input  logic clk_slow,
  input  logic rst_n,
  input  logic gate_req,
  output logic gate_on
);
  logic req_m_q, gate_q;

  always_ff @(negedge clk_slow or negedge rst_n) begin
    if (!rst_n) begin
      req_m_q <= 1'b1;
      gate_q  <= 1'b1;
    end else begin
      req_m_q <= gate_req;
      gate_q  <= req_m_q;
    end
  end

  assign gate_on = gate_q;
endmodule

// File: rtl/osc_switch_ctrl.sv
// Handover controller. Runs on falling edges of the base clock, so every
// gate change on the fast path happens while the base clock is low.
module osc_switch_ctrl
  import osc_pkg::*;
#(
  parameter int SEL_W        = 3,
  parameter int WARM_CYCLES  = 32000,
  parameter int SETTLE_EDGES = 8
) (
  input  logic                 clk_fast,
  input  logic                 rst_n,
  input  logic                 clk_slow,
  input  logic [SEL_W-1:0]     sel,
  input  logic [(1<<SEL_W)-3:0] div_cnt,
  input  logic                 slow_on,
  output logic                 fast_en,
  output logic [SEL_W-1:0]     fast_tap,
  output logic                 slow_req,
  output logic                 stable
);
  localparam int NTAP   = (1 << SEL_W) - 1;
  localparam int WCNT_W = $clog2(WARM_CYCLES + 1);
  localparam int ECNT_W = $clog2(SETTLE_EDGES + 1);
  localparam logic [SEL_W-1:0]  TOP_CODE = SEL_W'(NTAP);
  localparam logic [WCNT_W-1:0] WLAST    = WCNT_W'(WARM_CYCLES - 1);
  localparam logic [ECNT_W-1:0] ELAST    = ECNT_W'(SETTLE_EDGES - 1);

  // Level of every fast tap as seen at a falling base edge. The undivided
  // tap is low right after its own falling edge; code 0 has no fast tap.
  logic [NTAP:0] lvl;
  assign lvl[0]    = 1'b0;
  assign lvl[NTAP] = 1'b0;
  for (genvar c = 1; c < NTAP; c++) begin : g_lvl
    assign lvl[c] = div_cnt[NTAP-1-c];
  end

  // Synchronizers into this domain
  logic [SEL_W-1:0] sel_m_q, sel_s_q;
  logic             sl_m_q, sl_s_q, sl_p_q;
  logic             ak_m_q, ak_s_q;

  always_ff @(negedge clk_fast or negedge rst_n) begin
    if (!rst_n) begin
      sel_m_q <= '0;
      sel_s_q <= '0;
      sl_m_q  <= 1'b0;
      sl_s_q  <= 1'b0;
      sl_p_q  <= 1'b0;
      ak_m_q  <= 1'b1;
      ak_s_q  <= 1'b1;
    end else begin
      sel_m_q <= sel;
      sel_s_q <= sel_m_q;
      sl_m_q  <= clk_slow;
      sl_s_q  <= sl_m_q;
      sl_p_q  <= sl_s_q;
      ak_m_q  <= slow_on;
      ak_s_q  <= ak_m_q;
    end
  end

  // Controller state
  osc_phase_e        ph_q, ph_n;
  logic [SEL_W-1:0]  eff_q, eff_n;
  logic [SEL_W-1:0]  pend_q, pend_n;
  logic [SEL_W-1:0]  ftap_q, ftap_n;
  logic              fen_q, fen_n;
  logic              sreq_q, sreq_n;
  logic              tprev_q, tprev_n;
  logic [ECNT_W-1:0] ecnt_q, ecnt_n;
  logic              wrun_q, wrun_n;
  logic              wdone_q, wdone_n;
  logic [WCNT_W-1:0] wcnt_q, wcnt_n;
  logic              stab_q, stab_n;

  logic cur_lvl, fall_f, fall_s, retarget, settle_fall;

  always_comb begin
    cur_lvl     = lvl[ftap_q];
    fall_f      = (ftap_q == TOP_CODE) | (tprev_q & ~cur_lvl);
    fall_s      = sl_p_q & ~sl_s_q;
    retarget    = (ph_q == PH_IDLE) ? (sel_s_q != eff_q) : (sel_s_q != pend_q);
    settle_fall = (pend_q == '0) ? fall_s : fall_f;

    ph_n    = ph_q;
    eff_n   = eff_q;
    pend_n  = pend_q;
    ftap_n  = ftap_q;
    fen_n   = fen_q;
    sreq_n  = sreq_q;
    tprev_n = cur_lvl;
    ecnt_n  = ecnt_q;
    wrun_n  = wrun_q;
    wdone_n = wdone_q;
    wcnt_n  = wcnt_q;

    // Warm-up timer in base cycles (two base edges per controller edge
    // are not needed: one falling edge is one base cycle)
    if (wrun_q) begin
      if (wcnt_q == WLAST) begin
        wrun_n  = 1'b0;
        wdone_n = 1'b1;
      end else begin
        wcnt_n = wcnt_q + 1'b1;
      end
    end

    if (retarget) begin
      pend_n = sel_s_q;
      ph_n   = PH_REL;
      ecnt_n = '0;
      if (sel_s_q == '0) begin
        wrun_n  = 1'b0;
        wdone_n = 1'b0;
      end else if (eff_q == '0) begin
        if (!wrun_q && !wdone_q) begin
          wrun_n = 1'b1;
          wcnt_n = '0;
        end
      end else begin
        wrun_n  = 1'b0;
        wdone_n = 1'b1;
      end
    end else begin
      unique case (ph_q)
        PH_REL: begin
          if (fen_q && !cur_lvl) fen_n = 1'b0;
          if (sreq_q && ak_s_q)  sreq_n = 1'b0;
          if (!fen_q && !sreq_q && !ak_s_q) ph_n = PH_ENG;
        end
        PH_ENG: begin
          if (pend_q != '0) begin
            if (!lvl[pend_q]) begin
              fen_n   = 1'b1;
              ftap_n  = pend_q;
              tprev_n = 1'b0;
              ph_n    = PH_SET;
            end
          end else begin
            sreq_n = 1'b1;
            if (ak_s_q) ph_n = PH_SET;
          end
        end
        PH_SET: begin
          if (settle_fall) begin
            if (ecnt_q == ELAST) begin
              eff_n = pend_q;
              ph_n  = PH_IDLE;
            end else begin
              ecnt_n = ecnt_q + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end

    stab_n = wdone_n && (eff_n != '0);
  end

  always_ff @(negedge clk_fast or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      eff_q   <= '0;
      pend_q  <= '0;
      ftap_q  <= '0;
      fen_q   <= 1'b0;
      sreq_q  <= 1'b1;
      tprev_q <= 1'b0;
      ecnt_q  <= '0;
      wrun_q  <= 1'b0;
      wdone_q <= 1'b0;
      wcnt_q  <= '0;
      stab_q  <= 1'b0;
    end else begin
      ph_q    <= ph_n;
      eff_q   <= eff_n;
      pend_q  <= pend_n;
      ftap_q  <= ftap_n;
      fen_q   <= fen_n;
      sreq_q  <= sreq_n;
      tprev_q <= tprev_n;
      ecnt_q  <= ecnt_n;
      wrun_q  <= wrun_n;
      wdone_q <= wdone_n;
      wcnt_q  <= wcnt_n;
      stab_q  <= stab_n;
    end
  end

  assign fast_en  = fen_q;
  assign fast_tap = ftap_q;
  assign slow_req = sreq_q;
  assign stable   = stab_q;
endmodule

// File: rtl/intosc_postscaler.sv
module intosc_postscaler #(
  parameter int SEL_W        = 3,
  parameter int WARM_CYCLES  = 32000,
  parameter int SETTLE_EDGES = 8
) (
  input  logic             clk_fast,
  input  logic             clk_slow,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] freq_sel,
  output logic             clk_out,
  output logic             freq_stable
);
  localparam int NTAP  = (1 << SEL_W) - 1;
  localparam int DIV_W = NTAP - 1;

  logic             rst_f_n, rst_s_n;
  logic [DIV_W-1:0] div_cnt;
  logic             fast_en, slow_req, slow_on;
  logic [SEL_W-1:0] fast_tap;
  logic [NTAP:0]    tap_clk;
  logic             fast_path, slow_path;

  osc_rst_sync #(.STAGES(2)) u_rst_f (
    .clk(clk_fast), .rst_n(rst_n), .rst_sync_n(rst_f_n)
  );

  osc_rst_sync #(.STAGES(2)) u_rst_s (
    .clk(clk_slow), .rst_n(rst_n), .rst_sync_n(rst_s_n)
  );

  osc_tap_divider #(.DIV_W(DIV_W)) u_div (
    .clk_fast(clk_fast), .rst_n(rst_f_n), .div_cnt(div_cnt)
  );

  osc_switch_ctrl #(
    .SEL_W(SEL_W), .WARM_CYCLES(WARM_CYCLES), .SETTLE_EDGES(SETTLE_EDGES)
  ) u_ctrl (
    .clk_fast(clk_fast), .rst_n(rst_f_n), .clk_slow(clk_slow),
    .sel(freq_sel), .div_cnt(div_cnt), .slow_on(slow_on),
    .fast_en(fast_en), .fast_tap(fast_tap), .slow_req(slow_req),
    .stable(freq_stable)
  );

  osc_slow_gate u_slow (
    .clk_slow(clk_slow), .rst_n(rst_s_n), .gate_req(slow_req),
    .gate_on(slow_on)
  );

  // Clock taps: top code is the base itself, code 0 carries no fast clock
  assign tap_clk[0]    = 1'b0;
  assign tap_clk[NTAP] = clk_fast;
  for (genvar c = 1; c < NTAP; c++) begin : g_tap
    assign tap_clk[c] = div_cnt[NTAP-1-c];
  end

  assign fast_path = fast_en & tap_clk[fast_tap];
  assign slow_path = slow_on & clk_slow;
  assign clk_out   = fast_path | slow_path;
endmodule

// File: rtl/intosc_postscaler_chk.sv
module intosc_postscaler_chk
  import osc_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input logic             clk_fast,
  input logic             rst_n,
  input logic             fast_en,
  input logic [SEL_W-1:0] fast_tap,
  input logic             slow_on,
  input logic             stable,
  input logic [SEL_W-1:0] eff,
  input logic [SEL_W-1:0] pend,
  input osc_phase_e       phase
);
  // R8: the two gated paths never conduct together
  assert_gate_mutex_R8: assert property (@(negedge clk_fast) disable iff (!rst_n)
    !(fast_en && slow_on));

  // R4: the fast path is only opened on a real tap code
  assert_fast_code_R4: assert property (@(negedge clk_fast) disable iff (!rst_n)
    fast_en |-> (fast_tap != '0));

  // R10: the flag only drops on the way to the slow source
  assert_stable_drop_R10: assert property (@(negedge clk_fast) disable iff (!rst_n)
    $fell(stable) |-> (pend == '0));

  // R7: a setting takes effect only from the edge-counting phase
  assert_effect_from_settle_R7: assert property (@(negedge clk_fast) disable iff (!rst_n)
    (eff != $past(eff)) |-> ($past(phase) == PH_SET));

  // R5: a settled flag at rest means the fast path is driving
  assert_stable_fast_R5: assert property (@(negedge clk_fast) disable iff (!rst_n)
    (stable && phase == PH_IDLE) |-> fast_en);
endmodule

bind intosc_postscaler intosc_postscaler_chk #(.SEL_W(SEL_W)) u_chk (
  .clk_fast(clk_fast),
  .rst_n(rst_f_n),
  .fast_en(fast_en),
  .fast_tap(fast_tap),
  .slow_on(slow_on),
  .stable(freq_stable),
  .eff(u_ctrl.eff_q),
  .pend(u_ctrl.pend_q),
  .phase(u_ctrl.ph_q)
);

// File: tb/sim_intosc_postscaler.sv
`timescale 1ns/1ps
module sim_intosc_postscaler;
  localparam int  WARM    = 2000;
  localparam time FPER    = 10;
  localparam time SPER    = 2560;

  logic       clk_fast, clk_slow, rst_n;
  logic [2:0] freq_sel;
  logic       clk_out, freq_stable;

  int checks = 0;
  int errors = 0;

  intosc_postscaler #(.SEL_W(3), .WARM_CYCLES(WARM), .SETTLE_EDGES(8)) u0 (
    .clk_fast(clk_fast), .clk_slow(clk_slow), .rst_n(rst_n),
    .freq_sel(freq_sel), .clk_out(clk_out), .freq_stable(freq_stable)
  );

  initial begin
    clk_fast = 1'b0;
    forever #(FPER/2) clk_fast = ~clk_fast;
  end

  initial begin
    clk_slow = 1'b0;
    #3;
    forever #(SPER/2) clk_slow = ~clk_slow;
  end

  // Pulse-width and edge monitor on the output clock
  time last_edge;
  time min_pulse;
  bit  have_edge;
  int  rise_cnt;

  always @(posedge clk_out or negedge clk_out) begin
    if (have_edge && ($time - last_edge) < min_pulse) min_pulse = $time - last_edge;
    last_edge = $time;
    have_edge = 1'b1;
    if (clk_out) rise_cnt++;
  end

  function automatic time exp_per(input int code);
    if (code == 0) return SPER;
    return FPER << (7 - code);
  endfunction

  function automatic time min_t(input time a, input time b);
    return (a < b) ? a : b;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk_fast);
    #1;
  endtask

  task automatic write_sel(input int code);
    @(posedge clk_fast);
    #1 freq_sel = 3'(code);
  endtask

  task automatic period_check(input int code, input string req);
    time t0, p1, p2;
    @(posedge clk_out); t0 = $time;
    @(posedge clk_out); p1 = $time - t0; t0 = $time;
    @(posedge clk_out); p2 = $time - t0;
    check(p1 == exp_per(code) && p2 == exp_per(code), req, "output period",
          longint'(p1), longint'(exp_per(code)));
  endtask

  function automatic int settle_cycles(input int from_c, input int to_c);
    return 12 + 2 * int'(exp_per(from_c) / FPER) + 10 * int'(exp_per(to_c) / FPER);
  endfunction

  // Switch between two nonzero codes with the flag watched on every cycle
  task automatic hop(input int from_c, input int to_c, input bit judge);
    int  low_seen = 0;
    int  n = settle_cycles(from_c, to_c);
    string rq = (to_c == 7) ? "R3" : "R4";
    write_sel(to_c);
    min_pulse = 64'hFFFF_FFFF;
    for (int i = 0; i < n; i++) begin
      @(posedge clk_fast);
      if (!freq_stable) low_seen++;
    end
    if (judge) begin
      check(low_seen == 0, "R9", "low flag cycles during hop", low_seen, 0);
      period_check(to_c, rq);
      check(min_pulse * 2 >= min_t(exp_per(from_c), exp_per(to_c)), "R8",
            "shortest pulse ns", longint'(min_pulse),
            longint'(min_t(exp_per(from_c), exp_per(to_c)) / 2));
    end
  endtask

  initial begin
    rst_n = 1'b0;
    freq_sel = 3'd0;
    have_edge = 1'b0;
    min_pulse = 64'hFFFF_FFFF;
    rise_cnt = 0;
    #(FPER * 7);
    rst_n = 1'b1;
    cycles(20);
    check(freq_stable == 1'b0, "R1", "flag after reset", freq_stable, 0);
    period_check(0, "R1");
    period_check(0, "R2");

    // Leave the slow source: warm-up timer and continued clocking
    begin
      int early_high = 0;
      write_sel(7);
      rise_cnt = 0;
      min_pulse = 64'hFFFF_FFFF;
      for (int i = 0; i < WARM - 10; i++) begin
        @(posedge clk_fast);
        if (freq_stable) early_high++;
      end
      check(early_high == 0, "R5", "flag high before warm-up", early_high, 0);
      check(rise_cnt > 100, "R6", "output rises during warm-up", rise_cnt, 101);
      cycles(50);
      check(freq_stable == 1'b1, "R5", "flag after warm-up", freq_stable, 1);
      period_check(7, "R3");
      check(min_pulse * 2 >= FPER, "R8", "shortest pulse leaving slow",
            longint'(min_pulse), longint'(FPER / 2));
    end

    // Every ordered pair of nonzero codes
    for (int a = 1; a <= 7; a++) begin
      if (a != 7 || 1 == 1) hop(7, a, 1'b0);
      for (int b = 1; b <= 7; b++) begin
        if (b != a) begin
          hop(a, b, 1'b1);
          hop(b, a, 1'b0);
        end
      end
      hop(a, 7, 1'b0);
    end

    // Back to the slow source
    write_sel(2);
    cycles(settle_cycles(7, 2));
    write_sel(0);
    min_pulse = 64'hFFFF_FFFF;
    cycles(6);
    check(freq_stable == 1'b0, "R10", "flag after move to slow", freq_stable, 0);
    cycles(settle_cycles(2, 0));
    period_check(0, "R10");
    check(min_pulse * 2 >= exp_per(2), "R8", "shortest pulse entering slow",
          longint'(min_pulse), longint'(exp_per(2) / 2));

    // Redirect while leaving the slow source
    write_sel(3);
    cycles(100);
    write_sel(5);
    min_pulse = 64'hFFFF_FFFF;
    cycles(WARM - 200);
    check(freq_stable == 1'b0, "R11", "flag before warm-up ends", freq_stable, 0);
    cycles(400);
    check(freq_stable == 1'b1, "R11", "flag after redirect", freq_stable, 1);
    period_check(5, "R11");

    // Redirect between nonzero codes
    begin
      int low_seen = 0;
      write_sel(2);
      cycles(10);
      write_sel(6);
      for (int i = 0; i < settle_cycles(2, 6) + 400; i++) begin
        @(posedge clk_fast);
        if (!freq_stable) low_seen++;
      end
      check(low_seen == 0, "R11", "low flag cycles on redirect", low_seen, 0);
      period_check(6, "R11");
    end

    // Redirect a pending move to slow back to a fast code
    write_sel(0);
    cycles(30);
    write_sel(1);
    min_pulse = 64'hFFFF_FFFF;
    cycles(4000);
    check(freq_stable == 1'b1, "R11", "flag after aborted move to slow", freq_stable, 1);
    period_check(1, "R11");
    check(min_pulse * 2 >= exp_per(6), "R8", "shortest pulse on abort",
          longint'(min_pulse), longint'(exp_per(6) / 2));

    // Reset again in the middle of fast operation
    rst_n = 1'b0;
    freq_sel = 3'd0;
    #(FPER * 5);
    rst_n = 1'b1;
    cycles(20);
    check(freq_stable == 1'b0, "R1", "flag after second reset", freq_stable, 0);
    period_check(0, "R1");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_fast);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule